// File: doc/BRIEF.md
# Four-Lane Word Serializer with Capture and Frame Clocks

This block turns one parallel sample word per channel into a serial bit stream per channel. It runs on a single clock whose rate is the bit rate, which is twelve times the sample rate. A 4-bit slot counter divides each word period into twelve bit slots. Two companion clocks are built by the same registered logic as the data, so they stay in step with it. The capture clock runs at half the bit rate, and a receiver latches data on both of its edges. The frame clock runs at the sample rate and marks where each word begins.

A pulse on the sample strobe captures the input words into a per-lane holding register. At each word boundary every lane loads its next word. That word is either the held sample or a test word, and one source select chooses it for all lanes together. The test words are an alternating deskew word, a half-zero/half-one sync word, and a user word built from three nibbles. The bit order can be switched between least-significant first and most-significant first, and the switch reverses test words as well. The source select, the bit order and the user nibbles are sampled only at a word boundary.

Top module: `quad_word_serializer`

## Requirements
- R1: While `rst` is high, `ser_out`, `cap_clk` and `frame_clk` are all 0. The first clock edge after `rst` falls is a word boundary: it outputs bit slot 0 of a newly loaded word.
- R2: `cap_clk` changes value on every clock edge after reset. It is 1 during even bit slots (0, 2, …, 10) and 0 during odd slots.
- R3: `frame_clk` is 1 during bit slots 0–5 and 0 during slots 6–11. Its rising edge comes on the same clock edge as slot 0, the first bit of a word.
- R4: With `pat_sel`=0 (live data) and `msb_first`=0, bit slot t of lane c carries bit t of that lane's held word. The held word for lane c is `sample_data[12c+11:12c]`.
- R5: With `pat_sel`=1 (deskew) and `msb_first`=0, every lane sends 1 in even slots and 0 in odd slots.
- R6: With `pat_sel`=2 (sync) and `msb_first`=0, every lane sends 0 in slots 0–5 and 1 in slots 6–11.
- R7: With `pat_sel`=3 (user word) and `msb_first`=0, slot 4k+j carries bit j of nibble k, where nibble k is `user_nibbles[4k+3:4k]` (k = 0..2, j = 0..3).
- R8: With `msb_first`=1, slot t carries bit 11−t of the word that R4–R7 define, for live data and for every test word.
- R9: `pat_sel`, `msb_first` and `user_nibbles` are sampled only on the clock edge that starts a word. A change in slots 1–11 leaves the rest of the current word unchanged.
- R10: All four lanes use the same source select and bit order. When a test word is selected, every lane sends it whatever its sample data.
- R11: When `sample_stb` is high on an edge, `sample_data` is captured into the holding registers; otherwise they keep their value. If a strobe falls on a word-boundary edge, the word loaded at that boundary is the value held before that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock (12× sample rate) |
| rst | input | 1 | Synchronous active-high reset |
| sample_stb | input | 1 | Captures `sample_data` into the holding registers |
| sample_data | input | 48 | Four 12-bit sample words, lane c at bits 12c+11:12c |
| pat_sel | input | 2 | Source: 0 live, 1 deskew, 2 sync, 3 user word |
| msb_first | input | 1 | 1 = most-significant bit first |
| user_nibbles | input | 12 | User word, nibble k at bits 4k+3:4k |
| ser_out | output | 4 | Serial data, one bit per lane |
| cap_clk | output | 1 | Half-bit-rate capture clock |
| frame_clk | output | 1 | Sample-rate frame marker |

## Verification
Live data uses a different random word on each lane, so a crossed lane or a bit-order fault shows up in the serial stream. Each test word is sent in both bit orders. The deskew and sync words differ under reversal, so they expose a missing reversal that the live data might hide. Settings are changed in the middle of a word to show that they wait for the next boundary. A run with the strobe high on every edge separates the word loaded at a boundary from the word captured on that same edge. A reset asserted mid-frame checks that the frame restarts cleanly.

// File: rtl/qser_pkg.sv
package qser_pkg;
  typedef enum logic [1:0] {
    SRC_LIVE   = 2'd0,
    SRC_DESKEW = 2'd1,
    SRC_SYNC   = 2'd2,
    SRC_USER   = 2'd3
  } src_sel_e;
endpackage

// File: rtl/qser_timer.sv
module qser_timer #(
  parameter int WORD_W = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  output logic                      boundary,
  output logic [$clog2(WORD_W)-1:0] slot,
  output logic                      cap_clk,
  output logic                      frame_clk
);
  localparam int CW   = $clog2(WORD_W);
  localparam int HALF = WORD_W / 2;
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [CW-1:0] slot_n;
  logic          run_q;

  assign boundary = (slot == LAST);
  assign slot_n   = boundary ? '0 : slot + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot      <= LAST;
      cap_clk   <= 1'b0;
      frame_clk <= 1'b0;
      run_q     <= 1'b0;
    end else begin
      slot      <= slot_n;
      cap_clk   <= ~slot_n[0];
      frame_clk <= (slot_n < CW'(HALF));
      run_q     <= 1'b1;
    end
  end

  AST_CAP_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cap_clk != $past(cap_clk)));                       // R2
  AST_FRAME_START: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_clk) |-> (slot == '0 && cap_clk));                // R3
  AST_FRAME_MID: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_clk) |-> (slot == CW'(HALF)));                    // R3
endmodule

// File: rtl/qser_pattern.sv
module qser_pattern
  import qser_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  src_sel_e          sel,
  input  logic [WORD_W-1:0] user_word,
  output logic [WORD_W-1:0] pat_word,
  output logic              use_live,
  output logic              is_deskew
);
  localparam int HALF = WORD_W / 2;

  logic [WORD_W-1:0] deskew_w;
  logic [WORD_W-1:0] sync_w;

  for (genvar i = 0; i < WORD_W; i++) begin : g_bits
    assign deskew_w[i] = ((i % 2) == 0);
    assign sync_w[i]   = (i >= HALF);
  end

  always_comb begin
    unique case (sel)
      SRC_DESKEW: pat_word = deskew_w;
      SRC_SYNC:   pat_word = sync_w;
      SRC_USER:   pat_word = user_word;
      default:    pat_word = '0;
    endcase
  end

  assign use_live  = (sel == SRC_LIVE);
  assign is_deskew = (sel == SRC_DESKEW);
endmodule

// File: rtl/qser_lane.sv
module qser_lane #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boundary,
  input  logic              sample_stb,
  input  logic [WORD_W-1:0] sample_word,
  input  logic              use_live,
  input  logic              is_deskew,
  input  logic [WORD_W-1:0] pat_word,
  input  logic              msb_first,
  output logic              ser_out
);
  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] shift_q;
  logic [WORD_W-1:0] src_w;
  logic [WORD_W-1:0] rev_w;
  logic [WORD_W-1:0] send_w;
  logic              dsk_q;

  assign src_w = use_live ? hold_q : pat_word;

  for (genvar i = 0; i < WORD_W; i++) begin : g_rev
    assign rev_w[i] = src_w[WORD_W-1-i];
  end

  assign send_w = msb_first ? rev_w : src_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      shift_q <= '0;
      ser_out <= 1'b0;
      dsk_q   <= 1'b0;
    end else begin
      if (sample_stb) hold_q <= sample_word;
      if (boundary) begin
        ser_out <= send_w[0];
        shift_q <= {1'b0, send_w[WORD_W-1:1]};
        dsk_q   <= is_deskew;
      end else begin
        ser_out <= shift_q[0];
        shift_q <= {1'b0, shift_q[WORD_W-1:1]};
      end
    end
  end

  AST_DESKEW_ALT: assert property (@(posedge clk) disable iff (rst)
    (dsk_q && !$past(boundary)) |-> (ser_out != $past(ser_out)));  // R5
  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
    !sample_stb |=> $stable(hold_q));                              // R11
endmodule

// File: rtl/quad_word_serializer.sv
module quad_word_serializer
  import qser_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int WORD_W = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sample_stb,
  input  logic [NCH*WORD_W-1:0] sample_data,
  input  logic [1:0]            pat_sel,
  input  logic                  msb_first,
  input  logic [WORD_W-1:0]     user_nibbles,
  output logic [NCH-1:0]        ser_out,
  output logic                  cap_clk,
  output logic                  frame_clk
);
  localparam int CW = $clog2(WORD_W);

  logic              boundary;
  logic [CW-1:0]     slot;
  logic [WORD_W-1:0] pat_word;
  logic              use_live;
  logic              is_deskew;
  src_sel_e          sel;

  assign sel = src_sel_e'(pat_sel);

  qser_timer #(.WORD_W(WORD_W)) u_timer (
    .clk(clk), .rst(rst), .boundary(boundary), .slot(slot),
    .cap_clk(cap_clk), .frame_clk(frame_clk)
  );

  qser_pattern #(.WORD_W(WORD_W)) u_pattern (
    .sel(sel), .user_word(user_nibbles), .pat_word(pat_word),
    .use_live(use_live), .is_deskew(is_deskew)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    qser_lane #(.WORD_W(WORD_W)) u_lane (
      .clk(clk), .rst(rst), .boundary(boundary), .sample_stb(sample_stb),
      .sample_word(sample_data[c*WORD_W +: WORD_W]),
      .use_live(use_live), .is_deskew(is_deskew), .pat_word(pat_word),
      .msb_first(msb_first), .ser_out(ser_out[c])
    );
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (ser_out == '0 || !rst));                      // R1
  AST_SLOT0_FRAME: assert property (@(posedge clk) disable iff (rst)
    (slot == '0) |-> (frame_clk && cap_clk));                     // R3
endmodule

// File: tb/quad_word_serializer_test.sv
module quad_word_serializer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sample_stb = 1'b0;
  logic [47:0] sample_data = '0;
  logic [1:0]  pat_sel = 2'd0;
  logic        msb_first = 1'b0;
  logic [11:0] user_nibbles = '0;
  logic [3:0]  ser_out;
  logic        cap_clk;
  logic        frame_clk;

  always #4 clk = ~clk;

  quad_word_serializer uut (
    .clk(clk), .rst(rst), .sample_stb(sample_stb), .sample_data(sample_data),
    .pat_sel(pat_sel), .msb_first(msb_first), .user_nibbles(user_nibbles),
    .ser_out(ser_out), .cap_clk(cap_clk), .frame_clk(frame_clk)
  );

  int tests = 0;
  int fails = 0;
  bit started = 0;
  bit done = 0;
  string phase_tag = "";

  // behavioural reference
  int          m_slot;
  int          m_pat;
  bit          m_msb;
  bit          m_inrst;
  logic [11:0] m_hold [4];
  logic [11:0] m_word [4];

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_slot = 11; m_pat = 0; m_msb = 0; m_inrst = 1;
      for (int c = 0; c < 4; c++) begin m_hold[c] = '0; m_word[c] = '0; end
    end else begin
      m_inrst = 0;
      m_slot = (m_slot + 1) % 12;
      if (m_slot == 0) begin
        m_pat = int'(pat_sel); m_msb = msb_first;
        for (int c = 0; c < 4; c++) begin
          for (int i = 0; i < 12; i++) begin
            case (m_pat)
              0: m_word[c][i] = m_hold[c][i];
              1: m_word[c][i] = (i % 2 == 0);
              2: m_word[c][i] = (i >= 6);
              default: m_word[c][i] = user_nibbles[(i / 4) * 4 + (i % 4)];
            endcase
          end
        end
      end
      if (sample_stb)
        for (int c = 0; c < 4; c++) m_hold[c] = sample_data[c*12 +: 12];
    end
  end

  function automatic string data_tag();
    if (phase_tag != "") return phase_tag;
    if (m_msb) return "R8";
    case (m_pat)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check_bit(string tag, logic act, logic exp, string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b (slot %0d)", tag, what, act, exp, m_slot);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      if (m_inrst) begin
        check_bit("R1", frame_clk, 1'b0, "frame_clk in reset");
        check_bit("R1", cap_clk, 1'b0, "cap_clk in reset");
        for (int c = 0; c < 4; c++) check_bit("R1", ser_out[c], 1'b0, "ser_out in reset");
      end else begin
        check_bit("R3", frame_clk, logic'(m_slot < 6), "frame_clk");
        check_bit("R2", cap_clk, logic'(m_slot % 2 == 0), "cap_clk");
        for (int c = 0; c < 4; c++)
          check_bit(data_tag(), ser_out[c],
                    m_word[c][m_msb ? 11 - m_slot : m_slot], "ser_out lane");
      end
    end
  end

  task automatic step(bit stb_all);
    @(negedge clk);
    sample_stb  = stb_all ? 1'b1 : (m_slot == 4);
    sample_data = {$urandom(), $urandom()};
  endtask

  task automatic frames(int n, bit stb_all);
    for (int k = 0; k < n * 12; k++) step(stb_all);
  endtask

  task automatic wait_slot(int s);
    while (m_slot != s) step(1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;                                   // R1 first word at first edge
    frames(4, 1'b0);                              // R4 live, LSB first
    wait_slot(3); phase_tag = "R9"; msb_first = 1'b1;
    frames(1, 1'b0); phase_tag = "";
    frames(3, 1'b0);                              // R8 live reversed
    for (int p = 1; p < 4; p++) begin             // R5 R6 R7 and R8 on test words
      for (int o = 0; o < 2; o++) begin
        wait_slot(7); phase_tag = "R9";
        pat_sel = 2'(p); msb_first = 1'(o); user_nibbles = 12'hC5A;
        frames(1, 1'b0); phase_tag = "";
        frames(2, 1'b0);
      end
    end
    wait_slot(4); phase_tag = "R9"; user_nibbles = 12'h3E1;   // mid-word nibble change
    frames(2, 1'b0);
    phase_tag = "R10"; msb_first = 1'b0;          // test word ignores lane data
    frames(2, 1'b1);
    wait_slot(2); phase_tag = "R11"; pat_sel = 2'd0;
    frames(4, 1'b1);                              // strobe on every edge
    phase_tag = "R1";
    wait_slot(8); rst = 1'b1;
    repeat (3) step(1'b0);
    rst = 1'b0;
    frames(2, 1'b0); phase_tag = "";
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 50000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule